// File: doc/BRIEF.md
# Display Memory Fetch Bus Master

This block is the real-time bus master that a display controller uses to pull character and attribute words out of an external display memory. The memory sits behind a 16-bit multiplexed address/data bus that the host processor normally owns. When a row fill is needed, once per character row during line flyback, the block takes a fetch request. It then drops its bus-request line and holds it through a programmable warning interval, so the processor can finish whatever bus cycle it has in progress. After that it runs a burst of back-to-back read cycles.

Each read cycle is three base-clock periods long. The word address goes out on the shared pins. A low-going address strobe captures it into external transparent latches. The pins are then released, both byte strobes fall together, and the 16-bit word is sampled at the end of the cycle. Every captured word goes to the row-buffer fill side with its position in the burst. After the last word, a one-cycle completion pulse is issued and the bus request is released in the same cycle. Bytes are addressed so that the even byte is on the upper half of the bus. A word therefore carries the address of its upper byte, and only the byte-address bits above bit 0 reach the pins.

Top module: `fbm_fetch_master`

## Requirements
- R1: Out of reset, `br_n`, `as_n`, `uds_n`, `lds_n` and `rw_n` are high, and `bus_oe`, `fill_valid` and `fetch_done` are low.
- R2: A `fetch_go` taken while idle with a non-zero `fetch_len` drives `br_n` low on the next cycle. `bus_oe` then stays low for exactly `warn_len` cycles with `br_n` low before the first address is driven. A `warn_len` of 0 drives the address on the very first cycle of the request.
- R3: Every word takes exactly three cycles, in this order. Address phase: `bus_oe` high, `as_n` high. Latch phase: `bus_oe` high, `as_n` low. Data phase: `as_n`, `uds_n` and `lds_n` low, `bus_oe` low. `bus_in` is sampled at the clock edge that ends the data phase.
- R4: `bus_out` carries the word address, which is byte-address bits [16:1]. Bit 0 of `fetch_base` is ignored. Each following word has the address one higher, modulo 2^16, and the address holds steady while `as_n` is low.
- R5: `uds_n` and `lds_n` always have the same value, and `rw_n` stays high (read) throughout.
- R6: In the cycle after each data phase, `fill_valid` is high for one cycle. `fill_word` then holds the sampled word and `fill_index` holds its position in the burst, counting from 0.
- R7: A burst fetches exactly `fetch_len` words, spaced three cycles apart with no gap. `fetch_done` pulses once, in the same cycle as the last `fill_valid`, with `br_n` already high in that cycle.
- R8: `bus_oe` is never high while `br_n` is high.
- R9: `fetch_go` is ignored while a request is in progress, and it is also ignored when `fetch_len` is 0. In both cases no extra request, word or completion pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock; one period is one third of a memory cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| fetch_go | input | 1 | Request a fetch burst (taken only when idle) |
| fetch_base | input | ADDR_W (17) | Byte address of the first word; bit 0 ignored |
| fetch_len | input | LEN_W | Number of words in the burst |
| warn_len | input | WARN_W | Warning interval in base-clock periods |
| bus_in | input | BUS_W (16) | Data read from the shared pins |
| bus_out | output | BUS_W (16) | Word address driven onto the shared pins |
| bus_oe | output | 1 | Output enable for the shared pins |
| as_n | output | 1 | Address strobe, active low |
| uds_n | output | 1 | Upper byte strobe, active low |
| lds_n | output | 1 | Lower byte strobe, active low |
| rw_n | output | 1 | Read/write line, held at read |
| br_n | output | 1 | Bus request to the host, active low |
| fill_valid | output | 1 | A fetched word is presented |
| fill_word | output | BUS_W (16) | Fetched word |
| fill_index | output | LEN_W | Position of the word within the burst |
| fetch_done | output | 1 | One-cycle pulse after the last word |

## Verification
The bench builds the block with WARN_W=4 and LEN_W=5, keeping the 16-bit bus. The all-ones warning interval of 15 periods and the longest burst of 31 words therefore both run in a few hundred cycles. The bench also starts a burst at the top of the 17-bit byte space, where the word address wraps from FFFF to 0000. It covers the zero-warning path, an odd start address, a zero-length request, and a second request that arrives while a burst is still running.

// File: rtl/fbm_pkg.sv
package fbm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WARN = 2'd1,
        ST_BUS  = 2'd2
    } fbm_state_e;

    typedef enum logic [1:0] {
        PH_ADDR  = 2'd0,
        PH_LATCH = 2'd1,
        PH_DATA  = 2'd2
    } fbm_phase_e;

    localparam int unsigned PHASES_PER_WORD = 3;

endpackage

// File: rtl/fbm_warn_timer.sv
module fbm_warn_timer #(
    parameter int unsigned WARN_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WARN_W-1:0] load_val,
    input  logic              run,
    output logic              final_tick
);
    typedef struct packed {
        logic [WARN_W-1:0] cnt;
    } warn_st_t;

    warn_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.cnt = load_val;
        end else if (run && st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - WARN_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // The last warning period is the one with the count at 1.
    assign final_tick = (st_q.cnt <= WARN_W'(1));

    // R2: while waiting, the count falls by exactly one per period.
    p_warn_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load && st_q.cnt != '0) |=> (st_q.cnt == $past(st_q.cnt) - WARN_W'(1)));

endmodule

// File: rtl/fbm_phase_seq.sv
module fbm_phase_seq
    import fbm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    output fbm_phase_e phase,
    output logic       word_end
);
    typedef struct packed {
        fbm_phase_e phase;
    } phase_st_t;

    phase_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!run) begin
            st_d.phase = PH_ADDR;
        end else begin
            unique case (st_q.phase)
                PH_ADDR:  st_d.phase = PH_LATCH;
                PH_LATCH: st_d.phase = PH_DATA;
                default:  st_d.phase = PH_ADDR;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{phase: PH_ADDR};
        else        st_q <= st_d;
    end

    assign phase    = st_q.phase;
    assign word_end = run && (st_q.phase == PH_DATA);

    // R3: the latch phase is always followed by the data phase.
    p_phase_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && st_q.phase == PH_LATCH) |=> (st_q.phase == PH_DATA));

    // R3: the phase wraps back to the address phase after the data phase.
    p_phase_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_DATA) |=> (st_q.phase == PH_ADDR));

endmodule

// File: rtl/fbm_addr_gen.sv
module fbm_addr_gen #(
    parameter int unsigned ADDR_W = 17,
    parameter int unsigned LEN_W  = 6,
    localparam int unsigned WADDR_W = ADDR_W - 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [WADDR_W-1:0] base_word,
    input  logic [LEN_W-1:0]   len,
    input  logic               step,
    output logic [WADDR_W-1:0] word_addr,
    output logic [LEN_W-1:0]   index,
    output logic               last
);
    typedef struct packed {
        logic [WADDR_W-1:0] waddr;
        logic [LEN_W-1:0]   remain;
        logic [LEN_W-1:0]   index;
    } addr_st_t;

    addr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.waddr  = base_word;
            st_d.remain = len;
            st_d.index  = '0;
        end else if (step) begin
            st_d.waddr  = st_q.waddr + WADDR_W'(1);
            st_d.remain = st_q.remain - LEN_W'(1);
            st_d.index  = st_q.index + LEN_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word_addr = st_q.waddr;
    assign index     = st_q.index;
    assign last      = (st_q.remain == LEN_W'(1));

    // R4: each finished word moves the address up by one, wrapping at the top.
    p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> (word_addr == $past(word_addr) + WADDR_W'(1)));

    // R6: each finished word moves the burst position up by one.
    p_index_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> (index == $past(index) + LEN_W'(1)));

endmodule

// File: rtl/fbm_fetch_master.sv
module fbm_fetch_master
    import fbm_pkg::*;
#(
    parameter int unsigned BUS_W  = 16,
    parameter int unsigned LEN_W  = 6,
    parameter int unsigned WARN_W = 8,
    localparam int unsigned ADDR_W = BUS_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_go,
    input  logic [ADDR_W-1:0] fetch_base,
    input  logic [LEN_W-1:0]  fetch_len,
    input  logic [WARN_W-1:0] warn_len,
    input  logic [BUS_W-1:0]  bus_in,
    output logic [BUS_W-1:0]  bus_out,
    output logic              bus_oe,
    output logic              as_n,
    output logic              uds_n,
    output logic              lds_n,
    output logic              rw_n,
    output logic              br_n,
    output logic              fill_valid,
    output logic [BUS_W-1:0]  fill_word,
    output logic [LEN_W-1:0]  fill_index,
    output logic              fetch_done
);
    typedef struct packed {
        fbm_state_e       state;
        logic             fill_valid;
        logic [BUS_W-1:0] fill_word;
        logic [LEN_W-1:0] fill_index;
        logic             done;
    } top_st_t;

    top_st_t st_d, st_q;

    logic             accept;
    logic             warn_final;
    fbm_phase_e       phase;
    logic             word_end;
    logic [BUS_W-1:0] word_addr;
    logic [LEN_W-1:0] word_index;
    logic             word_last;
    logic             in_bus;
    logic             unused_lsb;

    // Words are even-aligned: the low byte-address bit never reaches the pins.
    assign unused_lsb = fetch_base[0];

    assign accept = (st_q.state == ST_IDLE) && fetch_go && (fetch_len != '0);
    assign in_bus = (st_q.state == ST_BUS);

    fbm_warn_timer #(.WARN_W(WARN_W)) u_warn (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (accept),
        .load_val   (warn_len),
        .run        (st_q.state == ST_WARN),
        .final_tick (warn_final)
    );

    fbm_phase_seq u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (in_bus),
        .phase    (phase),
        .word_end (word_end)
    );

    fbm_addr_gen #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .base_word (fetch_base[ADDR_W-1:1]),
        .len       (fetch_len),
        .step      (word_end),
        .word_addr (word_addr),
        .index     (word_index),
        .last      (word_last)
    );

    always_comb begin
        st_d            = st_q;
        st_d.fill_valid = 1'b0;
        st_d.done       = 1'b0;
        unique case (st_q.state)
            ST_IDLE: begin
                if (accept) st_d.state = (warn_len == '0) ? ST_BUS : ST_WARN;
            end
            ST_WARN: begin
                if (warn_final) st_d.state = ST_BUS;
            end
            default: begin
                if (word_end) begin
                    st_d.fill_valid = 1'b1;
                    st_d.fill_word  = bus_in;
                    st_d.fill_index = word_index;
                    if (word_last) begin
                        st_d.state = ST_IDLE;
                        st_d.done  = 1'b1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{state: ST_IDLE, default: '0};
        else        st_q <= st_d;
    end

    // Pin decode from the registered state and phase.
    assign bus_oe     = in_bus && (phase != PH_DATA);
    assign bus_out    = bus_oe ? word_addr : '0;
    assign as_n       = !(in_bus && (phase != PH_ADDR));
    assign uds_n      = !(in_bus && (phase == PH_DATA));
    assign lds_n      = uds_n;
    assign rw_n       = 1'b1;
    assign br_n       = (st_q.state == ST_IDLE);
    assign fill_valid = st_q.fill_valid;
    assign fill_word  = st_q.fill_word;
    assign fill_index = st_q.fill_index;
    assign fetch_done = st_q.done;

    // R8: the pins are driven only while the bus is requested.
    p_oe_needs_br_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> !br_n);

    // R7: completion comes with the request already withdrawn.
    p_done_releases_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_done |-> br_n);

    // R4: the address holds while the external latch closes on it.
    p_latch_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!as_n && bus_oe) |-> $stable(bus_out));

    // R3: the byte strobes open only after a latch phase.
    p_ds_after_as_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(uds_n) |-> ($past(!as_n) && !as_n));

    // R6: a fill word always follows a data phase.
    p_fill_after_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |-> $past(!uds_n));

endmodule

// File: tb/fbm_fetch_master_bench.sv
module fbm_fetch_master_bench;
    localparam int CLK_PERIOD = 10;
    localparam int BUS_W  = 16;
    localparam int LEN_W  = 5;
    localparam int WARN_W = 4;
    localparam int ADDR_W = BUS_W + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic              fetch_go = 1'b0;
    logic [ADDR_W-1:0] fetch_base = '0;
    logic [LEN_W-1:0]  fetch_len = '0;
    logic [WARN_W-1:0] warn_len = '0;
    logic [BUS_W-1:0]  bus_in;
    logic [BUS_W-1:0]  bus_out;
    logic              bus_oe, as_n, uds_n, lds_n, rw_n, br_n;
    logic              fill_valid, fetch_done;
    logic [BUS_W-1:0]  fill_word;
    logic [LEN_W-1:0]  fill_index;

    fbm_fetch_master #(.BUS_W(BUS_W), .LEN_W(LEN_W), .WARN_W(WARN_W)) u_fbm_fetch_master (
        .clk(clk), .rst_n(rst_n), .fetch_go(fetch_go), .fetch_base(fetch_base),
        .fetch_len(fetch_len), .warn_len(warn_len), .bus_in(bus_in), .bus_out(bus_out),
        .bus_oe(bus_oe), .as_n(as_n), .uds_n(uds_n), .lds_n(lds_n), .rw_n(rw_n),
        .br_n(br_n), .fill_valid(fill_valid), .fill_word(fill_word),
        .fill_index(fill_index), .fetch_done(fetch_done)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [15:0] mem_word(input logic [15:0] wa);
        return {wa[7:0] ^ 8'h3C, wa[15:8] ^ 8'hA5};
    endfunction

    // Model of the external latch and memory.
    logic [15:0] latch_q = '0;
    assign bus_in = mem_word(latch_q);

    logic [15:0] exp_addr_q[$];
    logic [15:0] exp_word_q[$];
    int          exp_idx_q[$];
    int  exp_warn   = 0;
    int  warn_seen  = 0;
    bit  oe_seen    = 1'b0;
    int  as_since   = -1;
    int  fill_since = -1;
    bit  as_prev    = 1'b1;
    int  done_cnt   = 0;
    bit  mon_en     = 1'b0;

    // Monitor / scoreboard.
    always @(negedge clk) begin : mon
        logic [15:0] pa;
        logic [15:0] pw;
        int          pi;
        if (mon_en) begin
            chk(!(br_n && bus_oe), "R8", "bus driven without request", bus_oe, 0);
            if (!br_n) chk((uds_n == lds_n) && rw_n, "R5", "strobe pair/read",
                           {uds_n, lds_n, rw_n}, {uds_n, uds_n, 1'b1});
            if (!uds_n) chk(!bus_oe, "R3", "pins released in data phase", bus_oe, 0);

            if (!br_n && !oe_seen) begin
                if (bus_oe) begin
                    chk(warn_seen == exp_warn, "R2", "warning cycles", warn_seen, exp_warn);
                    oe_seen = 1'b1;
                end else begin
                    warn_seen++;
                end
            end

            if (as_since >= 0) as_since++;
            if (as_prev && !as_n) begin
                if (as_since > 0) chk(as_since == 3, "R3", "cycle length", as_since, 3);
                as_since = 0;
                chk(bus_oe, "R3", "address driven at strobe", bus_oe, 1);
                if (exp_addr_q.size() == 0) begin
                    chk(1'b0, "R9", "unexpected address strobe", bus_out, 0);
                end else begin
                    pa = exp_addr_q.pop_front();
                    chk(bus_out == pa, "R4", "word address", bus_out, pa);
                end
            end
            if (bus_oe && !as_n) latch_q = bus_out;

            if (fill_since >= 0) fill_since++;
            if (fill_valid) begin
                if (fill_since > 0) chk(fill_since == 3, "R7", "word spacing", fill_since, 3);
                fill_since = 0;
                if (exp_word_q.size() == 0) begin
                    chk(1'b0, "R9", "unexpected word", fill_word, 0);
                end else begin
                    pw = exp_word_q.pop_front();
                    pi = exp_idx_q.pop_front();
                    chk(fill_word == pw, "R6", "fill word", fill_word, pw);
                    chk(int'(fill_index) == pi, "R6", "fill index", fill_index, pi);
                end
            end

            if (fetch_done) begin
                chk(br_n, "R7", "request released at done", br_n, 1);
                chk(fill_valid, "R7", "done with last word", fill_valid, 1);
                chk(exp_word_q.size() == 0, "R7", "words left at done", exp_word_q.size(), 0);
                done_cnt++;
                fill_since = -1;
            end

            if (br_n) begin
                warn_seen = 0;
                oe_seen   = 1'b0;
                as_since  = -1;
            end
            as_prev = as_n;
        end
    end

    task automatic run_burst(input logic [16:0] base, input int len, input int warn,
                             input bit poke_busy);
        logic [15:0] wa;
        int start_cnt;
        for (int i = 0; i < len; i++) begin
            wa = base[16:1] + 16'(i);
            exp_addr_q.push_back(wa);
            exp_word_q.push_back(mem_word(wa));
            exp_idx_q.push_back(i);
        end
        exp_warn  = warn;
        start_cnt = done_cnt;
        @(negedge clk);
        fetch_base = base;
        fetch_len  = LEN_W'(len);
        warn_len   = WARN_W'(warn);
        fetch_go   = 1'b1;
        @(negedge clk);
        fetch_go = 1'b0;
        chk(!br_n, "R2", "request asserted", br_n, 0);
        if (poke_busy) begin
            @(negedge clk);
            fetch_base = 17'h00400;
            fetch_len  = LEN_W'(7);
            warn_len   = '0;
            fetch_go   = 1'b1;
            @(negedge clk);
            fetch_go = 1'b0;
        end
        for (int c = 0; c < 4000 && done_cnt == start_cnt; c++) @(posedge clk);
        chk(done_cnt == start_cnt + 1, "R7", "one done per burst", done_cnt, start_cnt + 1);
        repeat (3) @(negedge clk);
        chk(done_cnt == start_cnt + 1, "R7", "no extra done", done_cnt, start_cnt + 1);
    endtask

    bit finished = 1'b0;

    initial begin
        int dc;
        repeat (3) @(negedge clk);
        chk(br_n && as_n && uds_n && lds_n && rw_n && !bus_oe && !fill_valid && !fetch_done,
            "R1", "outputs in reset",
            {br_n, as_n, uds_n, lds_n, rw_n, bus_oe, fill_valid, fetch_done}, 8'hF8);
        rst_n = 1'b1;
        @(negedge clk);
        chk(br_n && as_n && uds_n && lds_n && rw_n && !bus_oe && !fill_valid && !fetch_done,
            "R1", "outputs after reset",
            {br_n, as_n, uds_n, lds_n, rw_n, bus_oe, fill_valid, fetch_done}, 8'hF8);
        mon_en = 1'b1;

        run_burst(17'h00100, 4, 3, 1'b0);    // R2 R6 nominal
        run_burst(17'h0ABC0, 2, 0, 1'b0);    // R2 zero warning
        run_burst(17'h01235, 3, 1, 1'b0);    // R4 odd byte address
        run_burst(17'h1FFFC, 5, 2, 1'b0);    // R4 wrap at top
        run_burst(17'h02000, 31, 15, 1'b0);  // R7 longest burst, R2 longest warning
        run_burst(17'h00010, 1, 4, 1'b0);    // R7 single word

        // R9: zero-length request ignored
        dc = done_cnt;
        @(negedge clk);
        fetch_len = '0; warn_len = WARN_W'(2); fetch_go = 1'b1;
        @(negedge clk);
        fetch_go = 1'b0;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            chk(br_n && !bus_oe, "R9", "zero length ignored", {br_n, bus_oe}, 2'b10);
        end
        chk(done_cnt == dc, "R9", "no done for zero length", done_cnt, dc);

        // R9: request while busy ignored
        run_burst(17'h00800, 3, 2, 1'b1);
        dc = done_cnt;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            chk(br_n, "R9", "no request after busy start", br_n, 1);
        end
        chk(done_cnt == dc && exp_addr_q.size() == 0, "R9", "busy start left no trace",
            done_cnt, dc);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule